// File: doc/BRIEF.md
# Multichannel Label Acceptance Filter

This block decides, on each of eight receive channels, whether a word carrying a given 8-bit label is accepted or discarded. Each channel owns a private 256-entry, one-bit-wide permission table that the incoming label indexes. The decision appears one clock after the channel's label strobe, as a valid flag and an accept flag. A valid flag with a low accept flag means discard.

Software fills the tables through a host port while the `prog_mode` input is high. One host write loads the same table entry in all eight channels at once. The host address picks the entry, and data bit c supplies the bit for channel c. Host reads return the eight channel bits of one entry in the same layout. While programming is under way, filtering is suspended and no word is accepted. Software drops `prog_mode` afterwards to resume normal filtering.

Top module: `label_filter_top`

## Requirements
- R1: After reset every table entry is 0, so any strobed label yields `acc_valid`=1 with `acc_ok`=0. `acc_valid`, `acc_ok` and `host_rdata` are all 0 out of reset.
- R2: `acc_valid[c]` is 1 exactly one clock after a cycle with `lbl_stb[c]`=1, and 0 otherwise.
- R3: With `prog_mode`=0, `acc_ok[c]` one clock after a strobe equals the stored table bit of channel c at the label on `lbl_val[8c+7:8c]`. A 1 accepts the word and a 0 discards it.
- R4: A strobe made while `prog_mode`=1 gives `acc_ok[c]`=0 one clock later, and `acc_valid[c]` is still raised.
- R5: A cycle with `host_wr`=1 and `prog_mode`=1 writes `host_wdata[c]` into entry `host_addr` of channel c, for c=0..7. Bits 15..8 of `host_wdata` are ignored. Byte and word cycles behave the same.
- R6: A cycle with `host_wr`=1 while `prog_mode`=0 leaves every table unchanged.
- R7: One clock after `host_rd`=1 with `prog_mode`=1, `host_rdata[c]` holds channel c's bit at `host_addr` and bits 15..8 are 0. In every other case `host_rdata` is 0.
- R8: If a read and a write target the same address in one cycle, the read returns the entry as it was before that write.
- R9: Channels decide independently, each with its own label in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Table programming enable; suspends filtering |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Table entry selected by the host |
| host_wdata | input | 16 | Host write data, bit c for channel c |
| host_rdata | output | 16 | Registered read data, bit c from channel c |
| lbl_stb | input | 8 | Per-channel label strobe |
| lbl_val | input | 64 | Per-channel labels, 8 bits each |
| acc_valid | output | 8 | Decision present, per channel |
| acc_ok | output | 8 | Word accepted, per channel |

## Verification
Two things can hit one table entry in the same cycle: a host read and a host write to the same address. The bench issues both together on an entry whose old and new contents differ. It expects the old contents on the next clock and the new contents on a later read. A second overlap comes from channels that strobe different labels in one cycle. The result is judged against a table model kept in the bench, which it updates only on writes made in programming mode.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int LF_NUM_CH  = 8;
  localparam int LF_LABEL_W = 8;
  localparam int LF_HOST_DW = 16;
endpackage

// File: rtl/lf_channel.sv
module lf_channel #(
  parameter int LABEL_W = lf_pkg::LF_LABEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_mode,
  input  logic               host_wr,
  input  logic [LABEL_W-1:0] host_addr,
  input  logic               host_wbit,
  input  logic               lbl_stb,
  input  logic [LABEL_W-1:0] lbl_val,
  output logic               host_bit,
  output logic               acc_valid,
  output logic               acc_ok
);
  localparam int DEPTH = 1 << LABEL_W;

  logic [DEPTH-1:0] tbl;

  function automatic logic pick(input logic [DEPTH-1:0] t, input logic [LABEL_W-1:0] idx);
    return t[idx];
  endfunction

  // named internal events
  wire write_hit  = prog_mode & host_wr;
  wire table_bit  = pick(tbl, lbl_val);
  wire accept_now = lbl_stb & ~prog_mode & table_bit;

  assign host_bit = pick(tbl, host_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (write_hit) begin
      tbl[host_addr] <= host_wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_ok    <= 1'b0;
    end else begin
      acc_valid <= lbl_stb;
      acc_ok    <= accept_now;
    end
  end

  // R2: decision one clock after strobe
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_stb |=> acc_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lbl_stb |=> !acc_valid);
  // R3: accept only with a decision
  assert_ok_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> acc_valid);
  // R4: no acceptance while programming
  assert_prog_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && lbl_stb) |=> !acc_ok);
  // R5: programmed bit lands in the table
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    write_hit |=> (tbl[$past(host_addr)] == $past(host_wbit)));
  // R6: writes outside programming mode are ignored
  assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && host_wr) |=> $stable(tbl));
endmodule

// File: rtl/lf_readback.sv
module lf_readback #(
  parameter int NUM_CH  = lf_pkg::LF_NUM_CH,
  parameter int HOST_DW = lf_pkg::LF_HOST_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_mode,
  input  logic               host_rd,
  input  logic [NUM_CH-1:0]  entry_bits,
  output logic [HOST_DW-1:0] host_rdata
);
  wire read_hit = prog_mode & host_rd;

  function automatic logic [HOST_DW-1:0] widen(input logic [NUM_CH-1:0] b);
    return HOST_DW'(b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= read_hit ? widen(entry_bits) : '0;
  end

  // R7: idle or locked reads return zero; upper byte always zero
  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !read_hit |=> (host_rdata == '0));
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata >> NUM_CH) == '0);
endmodule

// File: rtl/label_filter_top.sv
module label_filter_top #(
  parameter int NUM_CH  = lf_pkg::LF_NUM_CH,
  parameter int LABEL_W = lf_pkg::LF_LABEL_W,
  parameter int HOST_DW = lf_pkg::LF_HOST_DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_mode,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [LABEL_W-1:0]        host_addr,
  input  logic [HOST_DW-1:0]        host_wdata,
  output logic [HOST_DW-1:0]        host_rdata,
  input  logic [NUM_CH-1:0]         lbl_stb,
  input  logic [NUM_CH*LABEL_W-1:0] lbl_val,
  output logic [NUM_CH-1:0]         acc_valid,
  output logic [NUM_CH-1:0]         acc_ok
);
  localparam int UPPER_W = HOST_DW - NUM_CH;

  logic [NUM_CH-1:0]  entry_bits;
  wire  [UPPER_W-1:0] wdata_ignored = host_wdata[HOST_DW-1:NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lf_channel #(.LABEL_W(LABEL_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_mode (prog_mode),
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .host_wbit (host_wdata[c]),
      .lbl_stb   (lbl_stb[c]),
      .lbl_val   (lbl_val[c*LABEL_W +: LABEL_W]),
      .host_bit  (entry_bits[c]),
      .acc_valid (acc_valid[c]),
      .acc_ok    (acc_ok[c])
    );
  end

  lf_readback #(.NUM_CH(NUM_CH), .HOST_DW(HOST_DW)) u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_mode  (prog_mode),
    .host_rd    (host_rd),
    .entry_bits (entry_bits),
    .host_rdata (host_rdata)
  );

  // R5: upper write data never reaches the read path
  assert_upper_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && host_wr && host_rd && (wdata_ignored != '0)) |=> ((host_rdata >> NUM_CH) == '0));
  // R8: read in the write cycle sees the pre-write entry
  assert_read_before_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && host_rd) |=> (host_rdata == HOST_DW'($past(entry_bits))));
endmodule

// File: tb/test_label_filter_top.sv
`timescale 1ns/1ps
module test_label_filter_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [7:0]  lbl_stb = '0;
  logic [63:0] lbl_val = '0;
  logic [7:0]  acc_valid, acc_ok;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ref_tbl [256];

  always #2.5 clk = ~clk;

  label_filter_top i_label_filter_top (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lbl_stb(lbl_stb), .lbl_val(lbl_val), .acc_valid(acc_valid), .acc_ok(acc_ok));

  typedef struct packed { logic [7:0] label; logic [7:0] mask; logic [7:0] exp_ok; } vec_t;
  localparam vec_t VECS [7] = '{
    '{8'h00, 8'hFF, 8'h55}, '{8'h3A, 8'hFF, 8'h0F}, '{8'hFF, 8'hFF, 8'h80},
    '{8'hA5, 8'h0F, 8'h03}, '{8'hA5, 8'hF0, 8'hC0}, '{8'h01, 8'hFF, 8'h00},
    '{8'h3A, 8'h00, 8'h00}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic pm, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    prog_mode = pm; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (pm) ref_tbl[a] = d[7:0];
  endtask

  task automatic host_read(input logic pm, input logic [7:0] a, output logic [15:0] r);
    @(negedge clk);
    prog_mode = pm; host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    r = host_rdata;
  endtask

  task automatic strobe_all(input logic [7:0] lab, input logic [7:0] mask);
    @(negedge clk);
    lbl_stb = mask;
    for (int c = 0; c < 8; c++) lbl_val[c*8 +: 8] = lab;
    @(negedge clk);
    lbl_stb = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [7:0]  exp_ok;
    for (int i = 0; i < 256; i++) ref_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", {8'h0, acc_valid}, 16'h0);
    check("R1 ok", {8'h0, acc_ok}, 16'h0);
    check("R1 rdata", host_rdata, 16'h0);
    strobe_all(8'h00, 8'hFF);
    check("R1 reject", {acc_valid, acc_ok}, 16'hFF00);
    host_read(1'b1, 8'h77, rd);
    check("R1 empty entry", rd, 16'h0);

    // R5: programming, upper byte ignored
    host_write(1'b1, 8'h00, 16'hFF55);
    host_write(1'b1, 8'h3A, 16'h000F);
    host_write(1'b1, 8'hFF, 16'h0080);
    host_write(1'b1, 8'hA5, 16'hAAC3);
    host_read(1'b1, 8'h00, rd);
    check("R5/R7 readback", rd, 16'h0055);
    host_read(1'b1, 8'hA5, rd);
    check("R5/R7 readback", rd, 16'h00C3);

    // R2 R3: vector table
    prog_mode = 1'b0;
    for (int v = 0; v < 7; v++) begin
      strobe_all(VECS[v].label, VECS[v].mask);
      check("R2 valid", {8'h0, acc_valid}, {8'h0, VECS[v].mask});
      check("R3 accept", {8'h0, acc_ok}, {8'h0, VECS[v].exp_ok});
    end
    @(negedge clk);
    check("R2 valid drops", {8'h0, acc_valid}, 16'h0);

    // R7: locked read returns zero
    host_read(1'b0, 8'h00, rd);
    check("R7 locked read", rd, 16'h0);

    // R8: simultaneous read and write to one entry
    @(negedge clk);
    prog_mode = 1'b1; host_rd = 1'b1; host_wr = 1'b1; host_addr = 8'h3A; host_wdata = 16'h12F0;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    ref_tbl[8'h3A] = 8'hF0;
    check("R8 old value", host_rdata, 16'h000F);
    host_read(1'b1, 8'h3A, rd);
    check("R8 new value", rd, 16'h00F0);

    // R6: write while locked has no effect
    host_write(1'b0, 8'h3A, 16'h00FF);
    prog_mode = 1'b0;
    strobe_all(8'h3A, 8'hFF);
    check("R6 locked write", {8'h0, acc_ok}, 16'h00F0);
    host_read(1'b1, 8'h3A, rd);
    check("R6 entry kept", rd, 16'h00F0);

    // R4: strobes during programming are rejected
    prog_mode = 1'b1;
    strobe_all(8'h00, 8'hFF);
    check("R4 valid", {8'h0, acc_valid}, 16'h00FF);
    check("R4 ok", {8'h0, acc_ok}, 16'h0);

    // R9: distinct labels per channel in one cycle
    @(negedge clk);
    prog_mode = 1'b0;
    lbl_val = {8'hFF, 8'hA5, 8'h3A, 8'h3A, 8'hFF, 8'hA5, 8'h00, 8'h00};
    lbl_stb = 8'hFF;
    exp_ok = '0;
    for (int c = 0; c < 8; c++) exp_ok[c] = ref_tbl[lbl_val[c*8 +: 8]][c];
    @(negedge clk);
    lbl_stb = '0;
    check("R9 independent", {8'h0, acc_ok}, {8'h0, exp_ok});
    check("R9 expected", {8'h0, exp_ok}, 16'h00F1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule